// File: doc/BRIEF.md
# PLL Control Register Interlock Unit

This block is the software-visible control register for a clock generator that has a phase-locked loop. It holds an 8-bit VCO range multiplier, a loop enable, a clock-source choice, an interrupt enable and an automatic-bandwidth mode bit. It also enforces the rules that tie these fields together. The multiplier cannot change while the loop runs. A zero multiplier keeps the loop off and keeps the VCO away from the base clock. The VCO cannot be chosen while the multiplier is zero.

The block watches the loop's lock indication through a synchronizer. In automatic mode it raises a sticky lock-change flag on every entry into lock and on every exit from lock. The flag drives an interrupt request when interrupts are enabled. Software reads the control register to learn the current lock state, and that read also clears the flag. The analog loop and the glitch-free clock switch sit outside this block. The block only drives their enable and select lines.

Top module: `pll_ctl_interlock`

## Requirements
- R1: After reset the range register reads 0x40 (multiplier 64). The control register reads 0x00. `pll_irq` and `vco_src_sel` are 0.
- R2: A write to the range register (address 1) takes effect on the next clock when `pll_en` is 0. The write is ignored, and the stored value is kept, while `pll_en` is 1.
- R3: While the range register holds 0x00, `pll_en` and the source-select bit are 0. A control write that tries to set either bit leaves it at 0.
- R4: Writing 1 to the source-select bit (control bit 1) has no effect while the range value is 0x00.
- R5: With the automatic bit (control bit 3) set, every rising or falling transition of `lock_in` sets the lock-change flag (control read bit 7). The flag is set on the third rising clock edge after the input changes: two synchronizer stages, then the edge detector.
- R6: The flag is set whether or not the interrupt enable (control bit 2) is 1. `pll_irq` is 1 only when both the flag and the enable are 1.
- R7: With the automatic bit at 0, the flag reads as 0, `pll_irq` stays 0, and lock transitions set nothing.
- R8: The source-select bit can be set while `lock_in` is 0. `vco_src_sel` follows the bit, and 1 selects the VCO clock divided by two.
- R9: A read of the control register (address 0) that returns the flag set clears the flag on that clock edge. If a lock transition sets the flag on the same edge, the flag stays set.
- R10: Control read bit 6 returns the synchronized lock state. Writes to bits 6 and 7 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe; a control read clears a seen flag |
| bus_addr | input | 1 | 0 = control register, 1 = range register |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data of the addressed register, combinational |
| lock_in | input | 1 | Asynchronous lock indication from the loop |
| pll_en | output | 1 | Loop enable |
| range_val | output | 8 | VCO range multiplier |
| auto_bw | output | 1 | Automatic-bandwidth mode bit |
| irq_en | output | 1 | Interrupt enable bit |
| pll_irq | output | 1 | Interrupt request |
| vco_src_sel | output | 1 | 1 selects the VCO clock divided by two as base clock |

## Verification
The bench writes a new range while the loop is enabled. A design without the interlock would report the new value. It then programs a zero range and tries to turn on the loop and the VCO source. A design that misses either guard would show those bits set in the read-back. Lock transitions are timed to the clock edge: a flag that appears one edge early means a synchronizer stage is missing, and a flag that never appears on a falling lock transition means only rising edges are detected. Finally a clearing read is placed on the same edge as a new lock event. A design that gives the clear priority would lose that event and read the flag as 0.

// File: rtl/pll_ctl_pkg.sv
package pll_ctl_pkg;
  localparam int DATA_W = 8;
  localparam logic ADDR_CTRL  = 1'b0;
  localparam logic ADDR_RANGE = 1'b1;

  localparam int B_EN   = 0;
  localparam int B_SRC  = 1;
  localparam int B_IE   = 2;
  localparam int B_AUTO = 3;
  localparam int B_LOCK = 6;
  localparam int B_FLAG = 7;

  function automatic logic [DATA_W-1:0] ctrl_word(input logic en, input logic src,
                                                  input logic ie, input logic auto_m,
                                                  input logic lock, input logic flag);
    logic [DATA_W-1:0] w;
    w = '0;
    w[B_EN]   = en;
    w[B_SRC]  = src;
    w[B_IE]   = ie;
    w[B_AUTO] = auto_m;
    w[B_LOCK] = lock;
    w[B_FLAG] = flag & auto_m;
    return w;
  endfunction

  function automatic logic is_transition(input logic now_v, input logic was_v);
    return now_v ^ was_v;
  endfunction
endpackage

// File: rtl/pll_lock_edge.sv
module pll_lock_edge #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic lock_async,
  output logic lock_sync,
  output logic lock_chg
);
  import pll_ctl_pkg::*;

  logic [SYNC_STAGES-1:0] stage_q;
  logic                   last_q;

  generate
    for (genvar i = 0; i < SYNC_STAGES; i++) begin : g_sync
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stage_q[0] <= 1'b0;
          else        stage_q[0] <= lock_async;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stage_q[i] <= 1'b0;
          else        stage_q[i] <= stage_q[i-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) last_q <= 1'b0;
    else        last_q <= stage_q[SYNC_STAGES-1];
  end

  assign lock_sync = stage_q[SYNC_STAGES-1];
  assign lock_chg  = is_transition(stage_q[SYNC_STAGES-1], last_q);
endmodule

// File: rtl/pll_range_reg.sv
module pll_range_reg #(
  parameter int W = 8,
  parameter logic [W-1:0] RST_VAL = 8'h40
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_hit,
  input  logic [W-1:0] wdata,
  input  logic         loop_on,
  output logic [W-1:0] range_q,
  output logic         zero_now
);
  logic take;
  logic wr_zero;

  assign take    = wr_hit & ~loop_on;
  assign wr_zero = take & (wdata == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    range_q <= RST_VAL;
    else if (take) range_q <= wdata;
  end

  // zero now, or becoming zero on this edge
  assign zero_now = (range_q == '0) | wr_zero;
endmodule

// File: rtl/pll_ctrl_reg.sv
module pll_ctrl_reg (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_hit,
  input  logic       rd_hit,
  input  logic [3:0] wdata,
  input  logic       range_zero,
  input  logic       lock_chg,
  output logic       en_q,
  output logic       src_q,
  output logic       ie_q,
  output logic       auto_q,
  output logic       flag_q,
  output logic       set_ev,
  output logic       clr_ev
);
  import pll_ctl_pkg::*;

  assign set_ev = lock_chg & auto_q;
  assign clr_ev = rd_hit & flag_q & auto_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      src_q  <= 1'b0;
      ie_q   <= 1'b0;
      auto_q <= 1'b0;
    end else begin
      if (wr_hit) begin
        ie_q   <= wdata[B_IE];
        auto_q <= wdata[B_AUTO];
      end
      if (range_zero) begin
        en_q  <= 1'b0;
        src_q <= 1'b0;
      end else if (wr_hit) begin
        en_q  <= wdata[B_EN];
        src_q <= wdata[B_SRC];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       flag_q <= 1'b0;
    else if (!auto_q) flag_q <= 1'b0;
    else if (set_ev)  flag_q <= 1'b1;
    else if (clr_ev)  flag_q <= 1'b0;
  end
endmodule

// File: rtl/pll_ctl_interlock.sv
module pll_ctl_interlock #(
  parameter int SYNC_STAGES = 2,
  parameter logic [7:0] RANGE_RST = 8'h40
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bus_wr,
  input  logic       bus_rd,
  input  logic       bus_addr,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata,
  input  logic       lock_in,
  output logic       pll_en,
  output logic [7:0] range_val,
  output logic       auto_bw,
  output logic       irq_en,
  output logic       pll_irq,
  output logic       vco_src_sel
);
  import pll_ctl_pkg::*;

  logic lock_sync, lock_chg;
  logic range_zero;
  logic flag_q, set_ev, clr_ev;
  logic ctrl_wr, range_wr, ctrl_rd;

  assign ctrl_wr  = bus_wr & (bus_addr == ADDR_CTRL);
  assign range_wr = bus_wr & (bus_addr == ADDR_RANGE);
  assign ctrl_rd  = bus_rd & (bus_addr == ADDR_CTRL);

  pll_lock_edge #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
    .clk(clk), .rst_n(rst_n), .lock_async(lock_in),
    .lock_sync(lock_sync), .lock_chg(lock_chg)
  );

  pll_range_reg #(.W(DATA_W), .RST_VAL(RANGE_RST)) u_range (
    .clk(clk), .rst_n(rst_n), .wr_hit(range_wr), .wdata(bus_wdata),
    .loop_on(pll_en), .range_q(range_val), .zero_now(range_zero)
  );

  pll_ctrl_reg u_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_hit(ctrl_wr), .rd_hit(ctrl_rd),
    .wdata(bus_wdata[3:0]), .range_zero(range_zero), .lock_chg(lock_chg),
    .en_q(pll_en), .src_q(vco_src_sel), .ie_q(irq_en), .auto_q(auto_bw),
    .flag_q(flag_q), .set_ev(set_ev), .clr_ev(clr_ev)
  );

  assign pll_irq   = flag_q & auto_bw & irq_en;
  assign bus_rdata = (bus_addr == ADDR_RANGE) ? range_val :
                     ctrl_word(pll_en, vco_src_sel, irq_en, auto_bw, lock_sync, flag_q);
endmodule

// File: rtl/pll_ctl_interlock_chk.sv
module pll_ctl_interlock_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       bus_wr,
  input logic       bus_addr,
  input logic       pll_en,
  input logic       vco_src_sel,
  input logic [7:0] range_val,
  input logic       auto_bw,
  input logic       irq_en,
  input logic       pll_irq,
  input logic       lock_chg,
  input logic       flag_q
);
  AST_RANGE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr && pll_en) |=> $stable(range_val)); // R2
  AST_ZERO_RANGE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (range_val == 8'h00) |-> (!pll_en && !vco_src_sel)); // R3
  AST_SRC_NEEDS_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    vco_src_sel |-> (range_val != 8'h00)); // R4
  AST_LOCK_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_chg && auto_bw) |=> flag_q); // R5
  AST_IRQ_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    pll_irq |-> irq_en); // R6
  AST_MANUAL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !auto_bw |-> !pll_irq); // R7
endmodule

bind pll_ctl_interlock pll_ctl_interlock_chk u_chk (
  .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
  .pll_en(pll_en), .vco_src_sel(vco_src_sel), .range_val(range_val),
  .auto_bw(auto_bw), .irq_en(irq_en), .pll_irq(pll_irq),
  .lock_chg(lock_chg), .flag_q(flag_q)
);

// File: tb/pll_ctl_interlock_tb.sv
module pll_ctl_interlock_tb;
  localparam time CLK_PERIOD = 10ns;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_wr = 1'b0, bus_rd = 1'b0, bus_addr = 1'b0;
  logic [7:0] bus_wdata = 8'h00;
  logic [7:0] bus_rdata, range_val;
  logic lock_in = 1'b0;
  logic pll_en, auto_bw, irq_en, pll_irq, vco_src_sel;
  int total = 0, bad = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pll_ctl_interlock u_dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .lock_in(lock_in), .pll_en(pll_en),
    .range_val(range_val), .auto_bw(auto_bw), .irq_en(irq_en), .pll_irq(pll_irq),
    .vco_src_sel(vco_src_sel)
  );

  // vector: {write addr, write data, read addr, expected read}
  localparam logic [17:0] VEC [0:8] = '{
    {1'b1, 8'h10, 1'b1, 8'h10},  // R2 accepted while loop off
    {1'b0, 8'h01, 1'b0, 8'h01},  // loop on
    {1'b1, 8'h22, 1'b1, 8'h10},  // R2 ignored while loop on
    {1'b0, 8'hC0, 1'b0, 8'h00},  // R10 bits 6,7 not writable; loop off
    {1'b1, 8'h00, 1'b1, 8'h00},  // zero range accepted
    {1'b0, 8'h03, 1'b0, 8'h00},  // R3 R4 enable and source refused
    {1'b1, 8'h40, 1'b1, 8'h40},  // range back
    {1'b0, 8'h02, 1'b0, 8'h02},  // R8 source set with lock low
    {1'b0, 8'h00, 1'b0, 8'h00}
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic a, input logic [7:0] d);
    @(negedge clk); bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic rd(input logic a, output logic [7:0] v);
    @(negedge clk); bus_rd = 1'b1; bus_addr = a; #1 v = bus_rdata;
    @(negedge clk); bus_rd = 1'b0;
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin : main
    logic [7:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    rd(1'b1, v); chk("R1 range", v, 8'h40);
    rd(1'b0, v); chk("R1 ctrl", v, 8'h00);
    chk("R1 irq/src", {6'd0, pll_irq, vco_src_sel}, 8'h00);

    for (int i = 0; i < 9; i++) begin
      wr(VEC[i][17], VEC[i][16:9]);
      rd(VEC[i][8], v);
      chk($sformatf("R2/R3/R4/R8 vec%0d", i), v, VEC[i][7:0]);
      if (i == 7) chk("R8 src out", {7'd0, vco_src_sel}, 8'h01);
    end

    // R5 R6: auto + ie, rising lock
    wr(1'b0, 8'h0C);
    @(negedge clk); lock_in = 1'b1;
    repeat (2) @(negedge clk);
    chk("R5 not before third edge", {7'd0, pll_irq}, 8'h00);
    @(negedge clk);
    chk("R5 rising sets irq", {7'd0, pll_irq}, 8'h01);
    rd(1'b0, v); chk("R10 lock bit and R5 flag", v, 8'hCC);
    chk("R9 read clears", {7'd0, pll_irq}, 8'h00);
    // falling lock, interrupt disabled
    wr(1'b0, 8'h08);
    @(negedge clk); lock_in = 1'b0;
    repeat (3) @(negedge clk);
    chk("R6 no irq when disabled", {7'd0, pll_irq}, 8'h00);
    rd(1'b0, v); chk("R5 R6 falling sets flag", v, 8'h88);
    rd(1'b0, v); chk("R9 flag cleared", v, 8'h08);

    // R9 priority: set event on the clearing edge
    @(negedge clk); lock_in = 1'b1;
    repeat (3) @(negedge clk);
    lock_in = 1'b0;
    repeat (2) @(negedge clk);
    bus_rd = 1'b1; bus_addr = 1'b0; #1 v = bus_rdata;
    chk("R9 flag seen", v, 8'h88);
    @(negedge clk); bus_rd = 1'b0;
    rd(1'b0, v); chk("R9 set wins over clear", v, 8'h88);
    rd(1'b0, v); chk("R9 cleared afterwards", v, 8'h08);

    // R7: manual mode
    @(negedge clk); lock_in = 1'b1;
    repeat (3) @(negedge clk);
    wr(1'b0, 8'h04);
    rd(1'b0, v); chk("R7 flag hidden when auto off", v, 8'h44);
    chk("R7 no irq", {7'd0, pll_irq}, 8'h00);
    @(negedge clk); lock_in = 1'b0;
    repeat (4) @(negedge clk);
    wr(1'b0, 8'h0C);
    rd(1'b0, v); chk("R7 transition while manual sets nothing", v, 8'h0C);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule